// File: doc/BRIEF.md
# Symmetric-Tap Sequential FIR Engine

This block filters a stream of signed samples with an N-tap linear-phase FIR whose coefficients mirror about the centre, h(k) = h(N-1-k). It owns one multiplier and a bank of N partial-sum registers arranged in transposed form. It takes one sample through a ready/valid handshake and then processes it for a fixed number of cycles. When a sample is accepted, every partial sum moves one place toward the output and the far end starts from zero. The sequencer then spends N/2 cycles forming h(j)·x(n) for one half of the taps. Each product is added into both register j and its mirror N-1-j, so the multiplier does half the work of a plain sequential filter.

Register 0 holds y(n) once the last product lands. A one-cycle strobe marks the result, and the value stays on the output until the next sample is taken. The accumulator is wide enough that no combination of full-scale samples and coefficients can overflow it. The coefficient table is built at elaboration from a fixed formula.

Top module: `fir_sym_seq`

## Requirements
- R1: While rst is high at a rising edge the block clears itself. After that edge in_ready is 1, out_valid is 0, out_y is 0, and no earlier sample contributes to any later result.
- R2: For every accepted sample x(n), the result on out_y equals the sum over k = 0..N-1 of h(k)·x(n-k) in two's complement. Samples taken before the most recent reset count as zero.
- R3: The coefficients are symmetric, h(k) = h(N-1-k). For j < N/2, h(j) = ((7·j + 3) mod 23) - 11. With N = 8 the impulse response is -8, -1, 6, -10, -10, 6, -1, -8.
- R4: A sample is taken on a rising edge where in_valid and in_ready are both high. in_ready then stays low for exactly N/2+1 cycles, and the multiplier is used for exactly N/2 of them. in_valid has no effect while in_ready is low.
- R5: out_valid is high for exactly one cycle. It rises on the N/2-th rising edge after the accepting edge.
- R6: out_y is unchanged from the cycle out_valid is high until the edge that accepts the next sample.
- R7: The accumulator is XW+CW+ceil(log2 N) bits wide. Full-scale samples of either sign, aligned with the coefficient signs, give the exact sum.
- R8: A reset while a sample is being processed drops that sample without any out_valid pulse, and the next result has no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The engine is idle and takes a sample this cycle |
| in_sample | input | XW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_y | output | XW+CW+clog2(N) | Signed filter result |

## Verification
The accepting edge is edge 0. in_ready falls right after it. out_valid and the new out_y appear after edge N/2, and in_ready returns after edge N/2+1. The reference model in the bench counts edges from each accept in the same way and holds its expected ready, strobe and result for the cycle between edges. Every output is compared on the falling edge, so each value is read halfway between the register update that produced it and the next one. Outside those cycles the bench also requires out_y to keep its last value.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  // Coefficient for the unique half of the taps (index j < N/2).
  function automatic int coef_formula(input int j);
    return ((7 * j + 3) % 23) - 11;
  endfunction

  // Accumulator width that cannot overflow for N products.
  function automatic int acc_width(input int xw, input int cw, input int n);
    return xw + cw + $clog2(n);
  endfunction

  // Width of a step counter over `half` values, never zero.
  function automatic int step_width(input int half);
    return (half > 1) ? $clog2(half) : 1;
  endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
  parameter int HALF = 4,
  parameter int CW   = 8,
  parameter int SW   = 2
) (
  input  logic [SW-1:0]        idx,
  output logic signed [CW-1:0] coef
);
  logic signed [CW-1:0] table_q [HALF];

  for (genvar j = 0; j < HALF; j++) begin : g_entry
    assign table_q[j] = CW'(fir_sym_pkg::coef_formula(j));
  end

  always_comb begin
    coef = '0;
    for (int j = 0; j < HALF; j++) begin
      if (int'(idx) == j) coef = table_q[j];
    end
  end
endmodule

// File: rtl/fir_mul.sv
module fir_mul #(
  parameter int XW = 12,
  parameter int CW = 8,
  parameter int AW = 23
) (
  input  logic signed [XW-1:0] x,
  input  logic signed [CW-1:0] c,
  output logic signed [AW-1:0] p
);
  localparam int PW = XW + CW;
  logic signed [PW-1:0] full;

  assign full = x * c;
  assign p    = {{(AW-PW){full[PW-1]}}, full};
endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl #(
  parameter int HALF = 4,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          mac_en,
  output logic [SW-1:0] step,
  output logic          done
);
  import fir_sym_pkg::*;

  seq_state_t    state_q;
  logic [SW-1:0] step_q;
  logic          last_step;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign mac_en    = (state_q == ST_MAC);
  assign done      = (state_q == ST_DONE);
  assign step      = step_q;
  assign last_step = (step_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_MAC;
            step_q  <= SW'(HALF - 1);
          end
        end
        ST_MAC: begin
          if (last_step) state_q <= ST_DONE;
          else           step_q  <= step_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fir_ps_bank.sv
module fir_ps_bank #(
  parameter int N  = 8,
  parameter int AW = 23,
  parameter int SW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 mac_en,
  input  logic [SW-1:0]        step,
  input  logic signed [AW-1:0] prod,
  output logic signed [AW-1:0] y
);
  logic signed [AW-1:0] tap_q [N];
  logic [N-1:0]         hit;

  for (genvar k = 0; k < N; k++) begin : g_tap
    localparam int MIRROR = N - 1 - k;
    logic signed [AW-1:0] r_q;
    logic signed [AW-1:0] upstream;

    if (k == N - 1) begin : g_end
      assign upstream = '0;
    end else begin : g_mid
      assign upstream = tap_q[k+1];
    end

    assign hit[k]   = mac_en && ((int'(step) == k) || (int'(step) == MIRROR));
    assign tap_q[k] = r_q;

    always_ff @(posedge clk) begin
      if (rst)           r_q <= '0;
      else if (shift_en) r_q <= upstream;
      else if (hit[k])   r_q <= r_q + prod;
    end
  end

  assign y = tap_q[0];
endmodule

// File: rtl/fir_sym_seq.sv
module fir_sym_seq #(
  parameter int N  = 8,
  parameter int XW = 12,
  parameter int CW = 8
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            in_valid,
  output logic                                            in_ready,
  input  logic [XW-1:0]                                   in_sample,
  output logic                                            out_valid,
  output logic [fir_sym_pkg::acc_width(XW, CW, N)-1:0]    out_y
);
  localparam int HALF = N / 2;
  localparam int AW   = fir_sym_pkg::acc_width(XW, CW, N);
  localparam int SW   = fir_sym_pkg::step_width(HALF);

  logic                 accept;
  logic                 mac_en;
  logic [SW-1:0]        step;
  logic signed [XW-1:0] x_q;
  logic signed [CW-1:0] coef;
  logic signed [AW-1:0] prod;
  logic signed [AW-1:0] y;

  always_ff @(posedge clk) begin
    if (rst)         x_q <= '0;
    else if (accept) x_q <= $signed(in_sample);
  end

  fir_seq_ctrl #(.HALF(HALF), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .mac_en(mac_en), .step(step), .done(out_valid)
  );

  fir_coef_rom #(.HALF(HALF), .CW(CW), .SW(SW)) u_rom (
    .idx(step), .coef(coef)
  );

  fir_mul #(.XW(XW), .CW(CW), .AW(AW)) u_mul (
    .x(x_q), .c(coef), .p(prod)
  );

  fir_ps_bank #(.N(N), .AW(AW), .SW(SW)) u_bank (
    .clk(clk), .rst(rst), .shift_en(accept), .mac_en(mac_en),
    .step(step), .prod(prod), .y(y)
  );

  assign out_y = y;
endmodule

// File: rtl/fir_sym_seq_chk.sv
module fir_sym_seq_chk #(
  parameter int N  = 8,
  parameter int XW = 12,
  parameter int CW = 8
) (
  input logic                                         clk,
  input logic                                         rst,
  input logic                                         in_ready,
  input logic                                         out_valid,
  input logic [fir_sym_pkg::acc_width(XW, CW, N)-1:0] out_y,
  input logic                                         accept,
  input logic                                         mac_en
);
  localparam int HALF = N / 2;
  logic [15:0] mac_cnt;

  always_ff @(posedge clk) begin
    if (rst)         mac_cnt <= '0;
    else if (accept) mac_cnt <= '0;
    else if (mac_en) mac_cnt <= mac_cnt + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid));

  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R4
  mac_count_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mac_cnt == 16'(HALF)));

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> $stable(out_y));
endmodule

bind fir_sym_seq fir_sym_seq_chk #(.N(N), .XW(XW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_y(out_y), .accept(accept), .mac_en(mac_en)
);

// File: tb/fir_sym_seq_bench.sv
`timescale 1ns/1ps
module fir_sym_seq_bench;
  localparam int N    = 8;
  localparam int XW   = 12;
  localparam int CW   = 8;
  localparam int AW   = XW + CW + $clog2(N);
  localparam int HALF = N / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [XW-1:0] in_sample = '0;
  wire           in_ready;
  wire           out_valid;
  wire [AW-1:0]  out_y;

  always #2 clk = ~clk;

  fir_sym_seq #(.N(N), .XW(XW), .CW(CW)) u_fir_sym_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_y(out_y)
  );

  int     errors = 0;
  int     checks = 0;
  bit     finished = 1'b0;
  string  tag = "R2";
  bit     capture = 1'b0;
  longint cap[$];
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural reference model
  longint hist[$];
  bit     m_busy = 1'b0;
  int     m_cnt = 0;
  longint m_y = 0;
  longint m_last = 0;
  bit     m_acc = 1'b0;

  function automatic int ref_h(input int k);
    int j;
    j = (k < HALF) ? k : N - 1 - k;
    return ((7 * j + 3) % 23) - 11;
  endfunction

  function automatic longint ref_y();
    longint s = 0;
    foreach (hist[i]) s += longint'(ref_h(i)) * hist[i];
    return s;
  endfunction

  always @(posedge clk) begin
    m_acc = 1'b0;
    if (rst) begin
      hist.delete();
      m_busy = 1'b0; m_cnt = 0; m_y = 0; m_last = 0;
    end else if (m_busy) begin
      if (m_cnt == HALF) begin m_busy = 1'b0; m_last = m_y; end
      else m_cnt++;
    end else if (in_valid) begin
      hist.push_front(longint'($signed(in_sample)));
      if (hist.size() > N) void'(hist.pop_back());
      m_y = ref_y();
      m_busy = 1'b1; m_cnt = 0; m_acc = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit     exp_ov;
      longint ys;
      ys     = longint'($signed(out_y));
      exp_ov = m_busy && (m_cnt == HALF);
      check(in_ready == !m_busy, (tag == "R8") ? "R8 ready" : "R4 ready", in_ready, !m_busy);
      check(out_valid == exp_ov, (tag == "R8") ? "R8 strobe" : "R5 strobe", out_valid, exp_ov);
      if (exp_ov) check(ys == m_y, {tag, " result"}, ys, m_y);
      else if (!m_busy) check(ys == m_last, "R6 hold", ys, m_last);
      if (capture && out_valid) cap.push_back(ys);
    end
  end

  task automatic send(input int x, input int gap);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = XW'(x);
    do @(negedge clk); while (!m_acc);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[XW-1:0]));
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset has been applied
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 strobe", out_valid, 0);
    check(out_y == '0, "R1 result", longint'($signed(out_y)), 0);
    rst = 1'b0;

    // R3: impulse response shows the coefficient table
    tag = "R3";
    capture = 1'b1;
    send(1, 0);
    for (int i = 1; i < N; i++) send(0, 0);
    repeat (HALF + 3) @(negedge clk);
    capture = 1'b0;
    check(cap.size() == N, "R3 count", cap.size(), N);
    if (cap.size() == N) begin
      for (int k = 0; k < N; k++) begin
        check(cap[k] == longint'(ref_h(k)), "R3 coef", cap[k], ref_h(k));
        check(cap[k] == cap[N-1-k], "R3 symmetry", cap[k], cap[N-1-k]);
      end
    end

    // R2: signed pseudo-random stream with varied gaps
    tag = "R2";
    for (int i = 0; i < 40; i++) send(next_rand(), i % 3);

    // R4: in_valid held high, sample changes every cycle
    tag = "R4";
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < 30; i++) begin
      in_sample = XW'(next_rand());
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (HALF + 3) @(negedge clk);

    // R7: full-scale samples aligned with coefficient signs
    tag = "R7";
    for (int s = 0; s < 2; s++) begin
      for (int k = N - 1; k >= 0; k--) begin
        bit neg;
        neg = (ref_h(k) < 0) ^ (s == 1);
        send(neg ? -(1 << (XW - 1)) : (1 << (XW - 1)) - 1, 0);
      end
    end
    repeat (HALF + 3) @(negedge clk);

    // R8: reset in the middle of processing
    tag = "R8";
    send(700, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(-300, 1);
    send(123, 0);
    repeat (HALF + 4) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule